// File: doc/BRIEF.md
# Sample Adaptive Edge Offset Corrector

This block applies an edge-shaped correction to a stream of 10- or 12-bit video samples held in 16-bit containers. Each input beat carries one centre sample and the two neighbours that an upstream fetch unit has already read along the current direction. The block compares the centre with each neighbour, forms a five-way shape class (valley, concave corner, flat, convex corner, peak), adds the signed correction programmed for that class, and clamps the result to the sample range.

The five corrections are written in one go through a load strobe before a block of rows is filtered, and they stay fixed while the rows stream through. The direction class is a static setting. The block decodes it into the relative positions of the two neighbours for the fetch unit. Samples move through a two-stage valid/ready pipeline at one per cycle, and a counter records how many filtered samples have left the block.

Top module: `sao_edge_corrector`

## Requirements
- R1: `dir_class` decodes to neighbour positions (dx,dy) for A and B: 0 gives A(-1,0) B(1,0); 1 gives A(0,-1) B(0,1); 2 gives A(-1,-1) B(1,1); 3 gives A(1,-1) B(-1,1). B is always the mirror of A.
- R2: Each neighbour contributes +1 when the centre is larger, -1 when it is smaller and 0 when they are equal, compared as unsigned values. The sum of the two contributions picks the correction slot: -2 picks slot 1, -1 picks slot 2, 0 picks slot 0, +1 picks slot 3, +2 picks slot 4.
- R3: A sum of centre and correction below zero is output as 0.
- R4: A sum above 2^DEPTH_BITS-1 is output as 2^DEPTH_BITS-1 (1023 at 10 bits, 4095 at 12 bits). No output ever exceeds that value.
- R5: In a flat region (sum 0), slot 0 is added as programmed, even when it is not zero.
- R6: `ofs_in` packs slot k as a 16-bit two's-complement value in bits [16k+15:16k]. It is captured only on a cycle with `ofs_load` high. On any other cycle, changes to `ofs_in` have no effect on the outputs.
- R7: A sample accepted at a clock edge appears on `out_sample` with `out_valid` after the second following edge. Back-to-back inputs give back-to-back outputs with no bubbles. `in_ready` is high whenever `out_valid` is low.
- R8: While `out_valid` is high and `out_ready` is low, `out_sample` holds steady. Once both stages are full, `in_ready` drops. No sample is lost or reordered.
- R9: `sample_count` rises by one for each cycle with `out_valid` and `out_ready` both high. On all other cycles it holds.
- R10: After reset, `out_valid` is 0, `sample_count` is 0, `in_ready` is 1 and all slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_class | input | 2 | Edge direction class |
| a_dx | output | 2 | Neighbour A horizontal position, signed |
| a_dy | output | 2 | Neighbour A vertical position, signed |
| b_dx | output | 2 | Neighbour B horizontal position, signed |
| b_dy | output | 2 | Neighbour B vertical position, signed |
| ofs_load | input | 1 | Capture the five corrections |
| ofs_in | input | 80 | Five packed signed 16-bit corrections |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| ctr_sample | input | 16 | Centre sample |
| nbr_a | input | 16 | Neighbour A sample |
| nbr_b | input | 16 | Neighbour B sample |
| out_valid | output | 1 | Filtered sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_sample | output | 16 | Filtered, clamped sample |
| sample_count | output | 16 | Number of samples delivered |

## Verification
The assertions assume three things about the inputs:
- Centre and neighbour samples carry no bits above the sample depth.
- Corrections are reloaded only while the pipeline is empty.
- `in_valid` is a plain level that the stall logic gates through `in_ready`.

The stimulus meets these assumptions. It uses only in-range sample values, and it pulses `ofs_load` only after the last output of a phase has drained. Its stall sequence fills both stages while `out_ready` is low, so the hold and back-pressure properties are exercised with the pipeline full.

// File: rtl/sao_edge_corrector.sv
module sao_edge_corrector #(
  parameter int DEPTH_BITS = 10,
  parameter int CONT_W     = 16,
  parameter int OFS_W      = 16,
  parameter int CNT_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           dir_class,
  output logic signed [1:0]    a_dx,
  output logic signed [1:0]    a_dy,
  output logic signed [1:0]    b_dx,
  output logic signed [1:0]    b_dy,
  input  logic                 ofs_load,
  input  logic [5*OFS_W-1:0]   ofs_in,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CONT_W-1:0]    ctr_sample,
  input  logic [CONT_W-1:0]    nbr_a,
  input  logic [CONT_W-1:0]    nbr_b,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CONT_W-1:0]    out_sample,
  output logic [CNT_W-1:0]     sample_count
);
  localparam int NSLOT = 5;
  localparam int SUM_W = ((CONT_W > OFS_W) ? CONT_W : OFS_W) + 2;
  localparam int MAX_I = (1 << DEPTH_BITS) - 1;
  localparam logic [CONT_W-1:0]       MAX_C = CONT_W'(MAX_I);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'(MAX_I);

  always_comb begin
    case (dir_class)
      2'd0:    begin a_dx = -2'sd1; a_dy =  2'sd0; end
      2'd1:    begin a_dx =  2'sd0; a_dy = -2'sd1; end
      2'd2:    begin a_dx = -2'sd1; a_dy = -2'sd1; end
      default: begin a_dx =  2'sd1; a_dy = -2'sd1; end
    endcase
  end
  assign b_dx = -a_dx;
  assign b_dy = -a_dy;

  logic [OFS_W-1:0] ofs_q [NSLOT];
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)        ofs_q[k] <= '0;
      else if (ofs_load) ofs_q[k] <= ofs_in[k*OFS_W +: OFS_W];
    end
  end

  logic signed [1:0] sg_a, sg_b;
  logic signed [2:0] edge_sum;
  logic [2:0]        slot_sel;
  assign sg_a = (ctr_sample > nbr_a) ? 2'sd1 : (ctr_sample < nbr_a) ? -2'sd1 : 2'sd0;
  assign sg_b = (ctr_sample > nbr_b) ? 2'sd1 : (ctr_sample < nbr_b) ? -2'sd1 : 2'sd0;
  assign edge_sum = 3'(sg_a) + 3'(sg_b);

  always_comb begin
    case (edge_sum)
      -3'sd2:  slot_sel = 3'd1;
      -3'sd1:  slot_sel = 3'd2;
       3'sd1:  slot_sel = 3'd3;
       3'sd2:  slot_sel = 3'd4;
      default: slot_sel = 3'd0;
    endcase
  end

  logic adv1, adv2;
  logic s1_v, s2_v;
  logic [CONT_W-1:0] s1_ctr, s2_q;
  logic [OFS_W-1:0]  s1_ofs;

  assign adv2     = !s2_v || out_ready;
  assign adv1     = !s1_v || adv2;
  assign in_ready = adv1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_ctr <= '0;
      s1_ofs <= '0;
    end else if (adv1) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_ctr <= ctr_sample;
        s1_ofs <= ofs_q[slot_sel];
      end
    end
  end

  logic signed [SUM_W-1:0] wide;
  logic [CONT_W-1:0]       clipped;
  assign wide = $signed({{(SUM_W-CONT_W){1'b0}}, s1_ctr})
              + $signed({{(SUM_W-OFS_W){s1_ofs[OFS_W-1]}}, s1_ofs});
  assign clipped = (wide < 0) ? '0 : (wide > MAX_S) ? MAX_C : wide[CONT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
      s2_q <= '0;
    end else if (adv2) begin
      s2_v <= s1_v;
      if (s1_v) s2_q <= clipped;
    end
  end

  assign out_valid  = s2_v;
  assign out_sample = s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      sample_count <= '0;
    else if (out_valid && out_ready) sample_count <= sample_count + 1'b1;
  end
endmodule

// File: rtl/sao_edge_corrector_chk.sv
module sao_edge_corrector_chk #(
  parameter int DEPTH_BITS = 10,
  parameter int CONT_W     = 16,
  parameter int CNT_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic signed [1:0] a_dx,
  input logic signed [1:0] a_dy,
  input logic signed [1:0] b_dx,
  input logic signed [1:0] b_dy,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CONT_W-1:0] out_sample,
  input logic [CNT_W-1:0]  sample_count
);
  localparam logic [CONT_W-1:0] MAX_C = CONT_W'((1 << DEPTH_BITS) - 1);

  p_dir_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_dx == -a_dx) && (b_dy == -a_dy));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sample <= MAX_C);

  p_empty_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> sample_count == $past(sample_count) + 1'b1);

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> $stable(sample_count));
endmodule

bind sao_edge_corrector sao_edge_corrector_chk #(
  .DEPTH_BITS(DEPTH_BITS), .CONT_W(CONT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a_dx(a_dx), .a_dy(a_dy), .b_dx(b_dx), .b_dy(b_dy),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_sample(out_sample), .sample_count(sample_count)
);

// File: tb/sao_edge_corrector_bench.sv
module sao_edge_corrector_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic rst_n;
  logic [1:0] dir_class;
  logic signed [1:0] a_dx, a_dy, b_dx, b_dy;
  logic ofs_load, in_valid, in_ready, out_valid, out_ready;
  logic [79:0] ofs_in;
  logic [15:0] ctr_sample, nbr_a, nbr_b, out_sample, sample_count;

  sao_edge_corrector u_sao_edge_corrector (
    .clk(clk), .rst_n(rst_n), .dir_class(dir_class),
    .a_dx(a_dx), .a_dy(a_dy), .b_dx(b_dx), .b_dy(b_dy),
    .ofs_load(ofs_load), .ofs_in(ofs_in),
    .in_valid(in_valid), .in_ready(in_ready),
    .ctr_sample(ctr_sample), .nbr_a(nbr_a), .nbr_b(nbr_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .sample_count(sample_count));

  logic d_ld, d_iv, d_ir, d_ov;
  logic signed [1:0] d_adx, d_ady, d_bdx, d_bdy;
  logic [79:0] d_ofs;
  logic [15:0] d_c, d_a, d_b, d_o, d_cnt;

  sao_edge_corrector #(.DEPTH_BITS(12)) u_sao_edge_corrector_d12 (
    .clk(clk), .rst_n(rst_n), .dir_class(2'd0),
    .a_dx(d_adx), .a_dy(d_ady), .b_dx(d_bdx), .b_dy(d_bdy),
    .ofs_load(d_ld), .ofs_in(d_ofs),
    .in_valid(d_iv), .in_ready(d_ir),
    .ctr_sample(d_c), .nbr_a(d_a), .nbr_b(d_b),
    .out_valid(d_ov), .out_ready(1'b1),
    .out_sample(d_o), .sample_count(d_cnt));

  localparam logic [15:0] VEC [12][4] = '{
    '{16'd500,  16'd500,  16'd500,  16'd505},
    '{16'd10,   16'd20,   16'd30,   16'd110},
    '{16'd10,   16'd10,   16'd30,   16'd17},
    '{16'd40,   16'd30,   16'd40,   16'd31},
    '{16'd300,  16'd100,  16'd200,  16'd100},
    '{16'd100,  16'd50,   16'd50,   16'd0},
    '{16'd1000, 16'd1010, 16'd1020, 16'd1023},
    '{16'd0,    16'd0,    16'd1,    16'd7},
    '{16'd1023, 16'd1023, 16'd0,    16'd1014},
    '{16'd50,   16'd60,   16'd40,   16'd55},
    '{16'd150,  16'd100,  16'd150,  16'd141},
    '{16'd199,  16'd199,  16'd199,  16'd204}
  };
  localparam logic [79:0] OFS_A = {16'hFF38, 16'hFFF7, 16'd7, 16'd100, 16'd5};

  logic [15:0] got [16];
  int stamp [16];
  int mon_n = 0;
  always @(negedge clk)
    if (rst_n && out_valid && out_ready && mon_n < 16) begin
      got[mon_n] = out_sample;
      stamp[mon_n] = cyc;
      mon_n = mon_n + 1;
    end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic send_one(input logic [15:0] c, input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] exp, input string tag);
    @(posedge clk); mon_n = 0;
    @(negedge clk);
    ctr_sample = c; nbr_a = a; nbr_b = b; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(mon_n == 1 && got[0] == exp, tag, int'(got[0]), int'(exp));
  endtask

  initial begin
    #(4*20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dir_class = 0; ofs_load = 0; ofs_in = '0; in_valid = 0; out_ready = 1;
    ctr_sample = 0; nbr_a = 0; nbr_b = 0;
    d_ld = 0; d_ofs = '0; d_iv = 0; d_c = 0; d_a = 0; d_b = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R10 out_valid", int'(out_valid), 0);
    check(sample_count == 0, "R10 count", int'(sample_count), 0);
    check(in_ready == 1, "R10 in_ready", int'(in_ready), 1);
    rst_n = 1;
    send_one(16'd300, 16'd100, 16'd100, 16'd300, "R10 slots zero");

    for (int d = 0; d < 4; d++) begin
      int ex_ax, ex_ay;
      dir_class = 2'(d); #1;
      ex_ax = (d == 1) ? 0 : (d == 3) ? 1 : -1;
      ex_ay = (d == 0) ? 0 : -1;
      check(int'(a_dx) == ex_ax && int'(a_dy) == ex_ay && int'(b_dx) == -ex_ax && int'(b_dy) == -ex_ay,
            "R1 direction decode", int'(a_dx) * 10 + int'(a_dy), ex_ax * 10 + ex_ay);
    end

    @(negedge clk); ofs_in = OFS_A; ofs_load = 1;
    @(negedge clk); ofs_load = 0;
    @(posedge clk); mon_n = 0;
    begin
      int c0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (i == 0) c0 = cyc;
        ctr_sample = VEC[i][0]; nbr_a = VEC[i][1]; nbr_b = VEC[i][2]; in_valid = 1;
      end
      @(negedge clk); in_valid = 0;
      repeat (3) @(negedge clk);
      check(mon_n == 12, "R7 output count", mon_n, 12);
      for (int i = 0; i < 12; i++)
        check(got[i] == VEC[i][3], "R2 R3 R4 R5 table", int'(got[i]), int'(VEC[i][3]));
      check(stamp[0] == c0 + 2, "R7 latency", stamp[0] - c0, 2);
      check(stamp[11] == stamp[0] + 11, "R7 no bubbles", stamp[11] - stamp[0], 11);
      check(sample_count == 13, "R9 count after table", int'(sample_count), 13);
    end

    @(posedge clk); mon_n = 0;
    @(negedge clk); out_ready = 0;
    ctr_sample = 50; nbr_a = 60; nbr_b = 70; in_valid = 1;
    @(negedge clk); ctr_sample = 300; nbr_a = 300; nbr_b = 300;
    @(negedge clk); ctr_sample = 200; nbr_a = 100; nbr_b = 100;
    check(in_ready == 0, "R8 in_ready drops when full", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    check(out_valid && out_sample == 150, "R8 held output", int'(out_sample), 150);
    check(sample_count == 13, "R9 count holds in stall", int'(sample_count), 13);
    out_ready = 1;
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);
    check(mon_n == 3 && got[0] == 150 && got[1] == 305 && got[2] == 0,
          "R8 order after stall", int'(got[1]), 305);
    check(sample_count == 16, "R9 count after stall", int'(sample_count), 16);

    @(negedge clk); ofs_in = {16'd1, 16'd1, 16'd1, 16'd1, 16'd50};
    send_one(16'd100, 16'd100, 16'd100, 16'd105, "R6 no capture without load");
    @(negedge clk); ofs_in = {16'hFF38, 16'hFFF7, 16'd7, 16'd100, 16'hFFFD}; ofs_load = 1;
    @(negedge clk); ofs_load = 0;
    send_one(16'd100, 16'd100, 16'd100, 16'd97, "R6 R5 reload slot0");

    @(negedge clk); d_ofs = {16'd200, 16'd0, 16'd0, 16'd100, 16'd0}; d_ld = 1;
    @(negedge clk); d_ld = 0;
    d_c = 4000; d_a = 3900; d_b = 3900; d_iv = 1;
    @(negedge clk); d_c = 1000; d_a = 2000; d_b = 2000;
    @(negedge clk); d_iv = 0;
    check(d_ov && d_o == 4095, "R4 12-bit ceiling", int'(d_o), 4095);
    @(negedge clk);
    check(d_ov && d_o == 1100, "R4 12-bit range", int'(d_o), 1100);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule